// File: doc/BRIEF.md
# Two-Segment Successive Approximation Sequencer

This block sequences a successive approximation converter whose reference is split in two: a resistor string chosen by the upper (coarse) bits and a charge-scaling capacitor sub-array driven by the lower (fine) bits. On a start pulse it runs one offset-cancellation cycle, then a binary search over the coarse segment code, then a binary search over the fine code. Each step reads the single comparator result.

The comparator input `cmp_hi` is 1 when the analog trial level, set by the present coarse and fine codes, is above the sampled input. During the coarse search every capacitor is held in parallel, so the trial level is the lower tap of the segment. During the fine search each fine LSB adds one sixteenth... more precisely one 2^-k fraction of a segment above that tap. The result word is the coarse code followed by the fine code.

Top module: `sar2_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `az_en` and `cap_par` are 0, and `coarse_code`, `fine_code` and `result` are all zeros.
- R2: A `start` seen at a clock edge while idle makes the next cycle the autozero cycle. In that one cycle `az_en`, `cap_par` and `busy` are 1.
- R3: The coarse phase lasts exactly COARSE_BITS cycles with `az_en` 0, `cap_par` 1 and `fine_code` 0. In its cycle i (i counted from 0), `coarse_code` holds the bits already decided, then a 1 at bit position COARSE_BITS-1-i, then zeros below it.
- R4: At the end of each search cycle, the bit under trial is cleared when `cmp_hi` is 1 and kept when `cmp_hi` is 0.
- R5: The fine phase starts only after the last coarse decision and lasts exactly FINE_BITS cycles with `cap_par` 0. During it `coarse_code` holds the final segment code, and `fine_code` is tried MSB first in the same way as in R3.
- R6: `busy` stays high for exactly 1 + COARSE_BITS + FINE_BITS cycles. `done` is high for exactly one cycle, the cycle right after the last fine decision, and `busy` is 0 in that cycle.
- R7: `result` equals {coarse_code, fine_code} from the cycle `done` is high, and it holds that value until the next `done`.
- R8: A `start` that arrives while `busy` is 1 is ignored. Timing and result of the conversion in progress do not change.
- R9: A `start` that arrives in the `done` cycle is accepted, and the next cycle is an autozero cycle.
- R10: With an ideal comparator, `result` equals the input level in LSB units. An input at or above full scale gives all ones, and an input of 0 gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a conversion when the block is idle |
| cmp_hi | input | 1 | Comparator result: 1 when the trial level is above the sampled input |
| az_en | output | 1 | Closes the offset-cancel switches (autozero cycle) |
| cap_par | output | 1 | Holds all capacitors in parallel (autozero and coarse phases) |
| busy | output | 1 | A conversion is in progress |
| coarse_code | output | COARSE_BITS | Resistor-string segment trial code |
| fine_code | output | FINE_BITS | Capacitor sub-array trial code |
| result | output | COARSE_BITS+FINE_BITS | Last converted word {coarse, fine} |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Two events can fall in the same cycle: a conversion finishing, where `done` rises and `result` is updated, and a new conversion being accepted. The bench raises `start` in the `done` cycle of one conversion. It then checks that the finished word is correct, and that the very next cycle is an autozero cycle for the chained conversion, whose own result is also checked. A `start` held high through the whole fine phase checks the opposite case: the conversion in progress must keep its timing and its word.

// File: rtl/sar2_pkg.sv
// Shared types for the two-segment successive approximation sequencer.
package sar2_pkg;
    // Conversion phase: idle, offset cancel, segment search, capacitor search
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_AZ   = 2'd1,
        PH_CRS  = 2'd2,
        PH_FIN  = 2'd3
    } phase_t;
endpackage

// File: rtl/sar2_sequencer.sv
// Phase sequencer: walks idle -> autozero (1 cycle) -> coarse (M cycles)
// -> fine (K cycles) -> idle and pulses done once.
// Assumes M and K are between 2 and 8, and that start is a synchronous level.
module sar2_sequencer
    import sar2_pkg::*;
#(
    parameter int M = 4,
    parameter int K = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   accept,
    output logic   last_step,
    output logic   done
);
    localparam int MAXW = (M > K) ? M : K;
    localparam int CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt;

    // Start is taken only in idle; last_step marks the final fine decision
    always_comb begin
        accept    = start && (phase == PH_IDLE);
        last_step = (phase == PH_FIN) && (cnt == '0);
    end

    // Phase and remaining-bit counter advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_step;
            case (phase)
                PH_IDLE: if (start) phase <= PH_AZ;
                PH_AZ: begin
                    phase <= PH_CRS;
                    cnt   <= CW'(M - 1);
                end
                PH_CRS: begin
                    if (cnt == '0) begin
                        phase <= PH_FIN;
                        cnt   <= CW'(K - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_FIN: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    az_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_AZ) |=> (phase == PH_CRS));
    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (phase != PH_AZ));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    fine_after_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIN) |-> ($past(phase) == PH_CRS || $past(phase) == PH_FIN));
endmodule

// File: rtl/sar2_bsearch.sv
// Binary search register: tries bits MSB first, setting each trial bit to 1
// and keeping it when the comparator says the trial level is not above input.
// Assumes W >= 2; clear loads the MSB trial, step decides one bit.
module sar2_bsearch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         show,
    input  logic         cmp_hi,
    output logic [W-1:0] code,
    output logic [W-1:0] kept_next
);
    localparam logic [W-1:0] TOP_BIT = W'(1) << (W - 1);

    logic [W-1:0] kept;
    logic [W-1:0] ptr;

    // Decision for the bit under trial, and the visible trial code
    always_comb begin
        kept_next = cmp_hi ? kept : (kept | ptr);
        code      = kept | (show ? ptr : '0);
    end

    // Kept bits and trial pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept <= '0;
            ptr  <= '0;
        end else if (clear) begin
            kept <= '0;
            ptr  <= TOP_BIT;
        end else if (step) begin
            kept <= kept_next;
            ptr  <= ptr >> 1;
        end
    end

    // R3
    ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr));
    // R4
    below_ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != '0) |-> ((kept & (ptr | (ptr - W'(1)))) == '0));
    // R3
    step_has_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (ptr != '0));
endmodule

// File: rtl/sar2_ctrl.sv
// Two-segment successive approximation controller: one autozero cycle, a
// coarse resistor-segment search, then a fine capacitor search.
// Assumes cmp_hi is valid in each search cycle for the codes presented then.
module sar2_ctrl
    import sar2_pkg::*;
#(
    parameter int COARSE_BITS = 4,
    parameter int FINE_BITS   = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             cmp_hi,
    output logic                             az_en,
    output logic                             cap_par,
    output logic                             busy,
    output logic [COARSE_BITS-1:0]           coarse_code,
    output logic [FINE_BITS-1:0]             fine_code,
    output logic [COARSE_BITS+FINE_BITS-1:0] result,
    output logic                             done
);
    localparam int NB = COARSE_BITS + FINE_BITS;

    phase_t               phase;
    logic                 accept;
    logic                 last_step;
    logic                 crs_act;
    logic                 fin_act;
    logic [COARSE_BITS-1:0] crs_next;
    logic [FINE_BITS-1:0]   fin_next;

    sar2_sequencer #(.M(COARSE_BITS), .K(FINE_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase     (phase),
        .accept    (accept),
        .last_step (last_step),
        .done      (done)
    );

    // Phase decode for switches and search enables
    always_comb begin
        crs_act = (phase == PH_CRS);
        fin_act = (phase == PH_FIN);
        az_en   = (phase == PH_AZ);
        cap_par = (phase == PH_AZ) || (phase == PH_CRS);
        busy    = (phase != PH_IDLE);
    end

    sar2_bsearch #(.W(COARSE_BITS)) u_crs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (crs_act),
        .show      (crs_act),
        .cmp_hi    (cmp_hi),
        .code      (coarse_code),
        .kept_next (crs_next)
    );

    sar2_bsearch #(.W(FINE_BITS)) u_fin (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (fin_act),
        .show      (fin_act),
        .cmp_hi    (cmp_hi),
        .code      (fine_code),
        .kept_next (fin_next)
    );

    // Result capture on the final fine decision
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else if (last_step) result <= {coarse_code, fin_next};
    end

    // R7
    result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == {coarse_code, fine_code}));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (!done || 1'b1) && ($past(last_step) || $stable(result)));
    // R3
    fine_idle_in_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_par && !az_en) |-> (fine_code == '0));
    // R9
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> az_en);
    // R6
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_act && $past(fin_act)) |-> $stable(coarse_code));

    logic unused_nb;
    assign unused_nb = ^crs_next ^ (NB[0]);
endmodule

// File: tb/sim_sar2_ctrl.sv
// Bench: exhaustive input sweep of a 3+3 bit configuration with an ideal
// comparator model; expected codes are computed arithmetically.
module sim_sar2_ctrl;
    localparam int M  = 3;
    localparam int K  = 3;
    localparam int N  = M + K;
    localparam int FS = (1 << N) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_hi;
    logic az_en, cap_par, busy, done;
    logic [M-1:0] coarse_code;
    logic [K-1:0] fine_code;
    logic [N-1:0] result;

    int vin = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Ideal comparator: trial level = coarse tap plus fine steps, in LSB units
    always_comb cmp_hi = ((int'(coarse_code) * (1 << K)) + int'(fine_code)) > vin;

    sar2_ctrl #(.COARSE_BITS(M), .FINE_BITS(K)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
        .az_en(az_en), .cap_par(cap_par), .busy(busy),
        .coarse_code(coarse_code), .fine_code(fine_code),
        .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion; started means start is already high from the done cycle
    task automatic run(input int v, input bit inject, input bit started, input bit chain_next);
        int vc;
        int cexp;
        int fexp;
        vc = (v > FS) ? FS : v;
        cexp = vc >> K;
        fexp = vc % (1 << K);
        if (!started) begin
            @(negedge clk);
            start = 1'b1;
        end
        vin = v;
        @(negedge clk);
        start = 1'b0;
        // R2: autozero cycle
        chk(az_en && cap_par && busy, "R2", {29'd0, az_en, cap_par, busy}, 7);
        for (int i = 0; i < M; i++) begin
            int te;
            @(negedge clk);
            te = (cexp & ~((1 << (M - i)) - 1)) | (1 << (M - 1 - i));
            // R3 / R4: coarse trial code, all capacitors in parallel
            chk(int'(coarse_code) == te, "R3", int'(coarse_code), te);
            chk(!az_en && cap_par && fine_code == '0 && busy, "R4", int'(fine_code), 0);
        end
        if (inject) start = 1'b1;
        for (int i = 0; i < K; i++) begin
            int te;
            @(negedge clk);
            te = (fexp & ~((1 << (K - i)) - 1)) | (1 << (K - 1 - i));
            // R5: fine search with the segment code held
            chk(int'(fine_code) == te, "R5", int'(fine_code), te);
            chk(int'(coarse_code) == cexp && !cap_par && busy && !done, "R5",
                int'(coarse_code), cexp);
        end
        start = 1'b0;
        @(negedge clk);
        // R6 / R8: done exactly after 1+M+K busy cycles, even with start injected
        chk(done && !busy, inject ? "R8" : "R6", {30'd0, done, busy}, 2);
        // R10 / R7: converted word
        chk(int'(result) == vc, "R10", int'(result), vc);
        chk(result == {coarse_code, fine_code}, "R7", int'(result),
            int'({coarse_code, fine_code}));
        if (chain_next) begin
            start = 1'b1;
        end else begin
            @(negedge clk);
            // R6 / R7: single pulse, result held
            chk(!done && !busy, "R6", {30'd0, done, busy}, 0);
            chk(int'(result) == vc, "R7", int'(result), vc);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(!busy && !done && !az_en && !cap_par && result == '0 && coarse_code == '0
            && fine_code == '0, "R1", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !az_en && !cap_par && result == '0, "R1", int'(busy), 0);
        // R10: full sweep plus out-of-range input
        for (int v = 0; v <= FS; v++) run(v, 1'b0, 1'b0, 1'b0);
        run(FS + 9, 1'b0, 1'b0, 1'b0);
        run(0, 1'b0, 1'b0, 1'b0);
        // R8: start held through the fine phase
        run(37, 1'b1, 1'b0, 1'b0);
        run(12, 1'b1, 1'b0, 1'b0);
        // R9: start in the done cycle chains a new conversion
        run(45, 1'b0, 1'b0, 1'b1);
        run(18, 1'b0, 1'b1, 1'b1);
        run(FS, 1'b0, 1'b1, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule